// File: doc/BRIEF.md
# Receive Alarm Interrupt Status Register

This block collects alarm and error events from the receive side of a DS3 framer into one byte of sticky interrupt flags. Six condition inputs are level signals: loss of signal, alarm indication, idle pattern, far-end failure, application-channel state and out-of-frame. The block samples each one on every clock and flags any change of its level, whether the condition starts or ends. Two further inputs are single-cycle error pulses, one for CP-bit errors and one for P-bit errors, and these set their flags directly.

Each flag passes through its own enable bit. Once set, a flag stays set until software reads the status offset. A read returns the flags as they stood before the read and clears them at the same clock edge. An event that arrives in the same cycle as that read is not lost: its flag is still set after the read, so the next read reports it.

A second offset returns the sampled levels of three of the conditions. The interrupt output is high whenever at least one flag is set.

Top module: `rx_alarm_irq_reg`

## Requirements
- R1: A synchronous reset clears all flags, the interrupt output and the sampled levels. A condition that is high when reset is released counts as a 0-to-1 change on the first clock after the release.
- R2: The status byte at offset 0x13 has this bit layout: bit 7 = CP-bit error, 6 = loss of signal, 5 = alarm indication, 4 = idle pattern, 3 = far-end failure, 2 = application-channel state, 1 = out-of-frame, 0 = P-bit error. The enable input `irq_en` uses the same bit positions.
- R3: A 0-to-1 change of a level input between two clock samples sets its flag at the clock edge that samples the new level.
- R4: A 1-to-0 change of a level input sets its flag in the same way.
- R5: Each cycle in which `err_cp` or `err_p` is high sets bit 7 or bit 0 at that clock edge.
- R6: An event whose `irq_en` bit is 0 leaves its flag unchanged. This holds for level changes and for error pulses.
- R7: While `rd_stb` is high and `rd_addr` is 0x13, `rd_data` shows the flags combinationally, before any clear. The flags are cleared at the clock edge that ends the strobe cycle.
- R8: An enabled event in the same cycle as a status read leaves its flag set after that edge.
- R9: A flag stays set across cycles with no read. A strobe at any offset other than 0x13 leaves all flags unchanged.
- R10: At offset 0x10, `rd_data` is {alarm indication, loss of signal, idle pattern, 5'b0}, using the levels sampled at the most recent clock edge. Every other offset except 0x13 reads as zero.
- R11: `irq` is active high and is 1 exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_los | input | 1 | Loss-of-signal level |
| cond_ais | input | 1 | Alarm-indication level |
| cond_idle | input | 1 | Idle-pattern level |
| cond_ferf | input | 1 | Far-end-failure level |
| cond_aic | input | 1 | Application-channel state level |
| cond_oof | input | 1 | Out-of-frame level |
| err_cp | input | 1 | CP-bit error pulse, one cycle per error |
| err_p | input | 1 | P-bit error pulse, one cycle per error |
| irq_en | input | 8 | Per-flag enables, same bit layout as the status byte |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, the status at 0x13 and the levels at 0x10. With these values it can strobe 0x12, which differs by a single bit from both decoded offsets, and confirm that such a near miss neither clears the flags nor returns data. The vector walk drives starts and ends of every condition, error pulses, reads that meet a new event in the same cycle, and fully masked enables. Directed steps then cover the level readout, the strobe at a foreign offset and a reset in mid-run that is released while a condition is still high.

// File: rtl/rx_alarm_irq_pkg.sv
package rx_alarm_irq_pkg;

    localparam int unsigned STAT_W = 8;
    localparam int unsigned N_LVL  = 6;

    // Status bit positions (software decodes these)
    localparam int unsigned B_CP   = 7;
    localparam int unsigned B_LOS  = 6;
    localparam int unsigned B_AIS  = 5;
    localparam int unsigned B_IDLE = 4;
    localparam int unsigned B_FERF = 3;
    localparam int unsigned B_AIC  = 2;
    localparam int unsigned B_OOF  = 1;
    localparam int unsigned B_P    = 0;

    // Index of each level within the packed level vector (status bit - 1)
    localparam int unsigned L_LOS  = B_LOS  - 1;
    localparam int unsigned L_AIS  = B_AIS  - 1;
    localparam int unsigned L_IDLE = B_IDLE - 1;

    typedef logic [STAT_W-1:0] stat_vec_t;
    typedef logic [N_LVL-1:0]  lvl_vec_t;

    typedef struct packed {
        logic cp_err;
        logic los;
        logic ais;
        logic idle;
        logic ferf;
        logic aic;
        logic oof;
        logic p_err;
    } stat_fields_t;

    typedef struct packed {
        logic       ais;
        logic       los;
        logic       idle;
        logic [4:0] rsvd;
    } lvl_byte_t;

    function automatic stat_vec_t merge_events(logic cp, lvl_vec_t chg, logic p);
        stat_fields_t f;
        f.cp_err = cp;
        f.los    = chg[L_LOS];
        f.ais    = chg[L_AIS];
        f.idle   = chg[L_IDLE];
        f.ferf   = chg[B_FERF-1];
        f.aic    = chg[B_AIC-1];
        f.oof    = chg[B_OOF-1];
        f.p_err  = p;
        return stat_vec_t'(f);
    endfunction

    function automatic lvl_byte_t pack_levels(lvl_vec_t lv);
        lvl_byte_t b;
        b.ais  = lv[L_AIS];
        b.los  = lv[L_LOS];
        b.idle = lv[L_IDLE];
        b.rsvd = '0;
        return b;
    endfunction

endpackage

// File: rtl/rxa_edge_det.sv
module rxa_edge_det #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] lvl_q,
    output logic [N-1:0] chg_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) lvl_q[i] <= 1'b0;
            else     lvl_q[i] <= lvl_i[i];
        end
        // Either direction of a level change counts as an event
        assign chg_o[i] = lvl_i[i] ^ lvl_q[i];
    end
endmodule

// File: rtl/rxa_sticky.sv
module rxa_sticky #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] stat_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)          stat_o[i] <= 1'b0;
            else if (set_i[i]) stat_o[i] <= 1'b1;   // set beats a clear in the same cycle
            else if (clr_i)   stat_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rxa_rd_mux.sv
module rxa_rd_mux
    import rx_alarm_irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned STAT_OFS = 'h13,
    parameter int unsigned LVL_OFS  = 'h10
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  stat_vec_t         stat_i,
    input  lvl_vec_t          lvl_i,
    output logic [STAT_W-1:0] data_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] LVL_A  = ADDR_W'(LVL_OFS);

    lvl_byte_t lb;
    assign lb = pack_levels(lvl_i);

    always_comb begin
        if (addr_i == STAT_A)     data_o = stat_i;
        else if (addr_i == LVL_A) data_o = lb;
        else                      data_o = '0;
    end
endmodule

// File: rtl/rx_alarm_irq_reg.sv
module rx_alarm_irq_reg
    import rx_alarm_irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned STAT_OFS = 'h13,
    parameter int unsigned LVL_OFS  = 'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cond_los,
    input  logic              cond_ais,
    input  logic              cond_idle,
    input  logic              cond_ferf,
    input  logic              cond_aic,
    input  logic              cond_oof,
    input  logic              err_cp,
    input  logic              err_p,
    input  logic [7:0]        irq_en,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    lvl_vec_t  lvl_in;
    lvl_vec_t  lvl_q;
    lvl_vec_t  lvl_chg;
    stat_vec_t ev_vec;
    stat_vec_t set_vec;
    stat_vec_t stat_q;
    logic      rd_clr;

    // Level vector order follows status bits 6..1
    assign lvl_in = {cond_los, cond_ais, cond_idle, cond_ferf, cond_aic, cond_oof};

    rxa_edge_det #(.N(N_LVL)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (lvl_in),
        .lvl_q (lvl_q),
        .chg_o (lvl_chg)
    );

    assign ev_vec  = merge_events(err_cp, lvl_chg, err_p);
    assign set_vec = ev_vec & irq_en;
    assign rd_clr  = rd_stb && (rd_addr == STAT_A);

    rxa_sticky #(.W(STAT_W)) u_sticky (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_vec),
        .clr_i  (rd_clr),
        .stat_o (stat_q)
    );

    rxa_rd_mux #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .LVL_OFS  (LVL_OFS)
    ) u_rd (
        .addr_i (rd_addr),
        .stat_i (stat_q),
        .lvl_i  (lvl_q),
        .data_o (rd_data)
    );

    assign irq = |stat_q;
endmodule

// File: rtl/rx_alarm_irq_chk.sv
module rx_alarm_irq_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned STAT_OFS = 'h13,
    parameter int unsigned LVL_OFS  = 'h10
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_stb,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [7:0]        irq_en,
    input logic              irq,
    input logic [7:0]        ev_vec,
    input logic [7:0]        stat_q
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] LVL_A  = ADDR_W'(LVL_OFS);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq);

    // R9
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !(rd_stb && rd_addr == STAT_A)) |=> irq);

    // R8
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|(ev_vec & irq_en)) |=> ((stat_q & $past(ev_vec & irq_en)) == $past(ev_vec & irq_en)));

    // R7
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr == STAT_A) |=> ((stat_q & ~$past(ev_vec & irq_en)) == 8'h00));

    // R6
    a_r6_only_enabled: assert property (@(posedge clk) disable iff (rst)
        (stat_q != $past(stat_q)) |-> ((stat_q & ~$past(stat_q) & ~$past(ev_vec & irq_en)) == 8'h00));

    // R11
    a_r11_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(ev_vec & irq_en)));

    // R10
    a_r10_other_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_addr != STAT_A && rd_addr != LVL_A) |-> (rd_data == 8'h00));
endmodule

bind rx_alarm_irq_reg rx_alarm_irq_chk #(
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS),
    .LVL_OFS  (LVL_OFS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq_en  (irq_en),
    .irq     (irq),
    .ev_vec  (ev_vec),
    .stat_q  (stat_q)
);

// File: tb/rx_alarm_irq_reg_test.sv
`timescale 1ns/100ps
module rx_alarm_irq_reg_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cond_los = 0, cond_ais = 0, cond_idle = 0;
    logic       cond_ferf = 0, cond_aic = 0, cond_oof = 0;
    logic       err_cp = 0, err_p = 0;
    logic [7:0] irq_en = 8'hFF;
    logic       rd_stb = 0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    rx_alarm_irq_reg uut (
        .clk(clk), .rst(rst),
        .cond_los(cond_los), .cond_ais(cond_ais), .cond_idle(cond_idle),
        .cond_ferf(cond_ferf), .cond_aic(cond_aic), .cond_oof(cond_oof),
        .err_cp(err_cp), .err_p(err_p), .irq_en(irq_en),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // Fields: [25:18] stimulus in status layout, [17:10] enables,
    // [9] status read this cycle, [8:1] expected read data, [0] irq after edge
    localparam logic [25:0] VEC [0:15] = '{
        {8'h00, 8'hFF, 1'b0, 8'h00, 1'b0},  // idle
        {8'h40, 8'hFF, 1'b0, 8'h00, 1'b1},  // R3 los rises
        {8'h40, 8'hFF, 1'b1, 8'h40, 1'b0},  // R7 read clears
        {8'h00, 8'hFF, 1'b0, 8'h00, 1'b1},  // R4 los falls
        {8'h20, 8'hFF, 1'b1, 8'h40, 1'b1},  // R8 ais rises during read
        {8'hA1, 8'hFF, 1'b1, 8'h20, 1'b1},  // R5 R8 both error pulses during read
        {8'h20, 8'hFF, 1'b1, 8'h81, 1'b0},  // R2 R5 pulse bits
        {8'h3E, 8'hFF, 1'b0, 8'h00, 1'b1},  // R3 idle ferf aic oof rise
        {8'h3E, 8'hFF, 1'b1, 8'h1E, 1'b0},  // R2 positions
        {8'h00, 8'hFF, 1'b0, 8'h00, 1'b1},  // R4 five conditions fall
        {8'h00, 8'hFF, 1'b1, 8'h3E, 1'b0},  // R2 R4
        {8'h7E, 8'h00, 1'b0, 8'h00, 1'b0},  // R6 all rise, masked
        {8'hFF, 8'h00, 1'b0, 8'h00, 1'b0},  // R6 pulses masked
        {8'h7E, 8'h00, 1'b1, 8'h00, 1'b0},  // R6 nothing latched
        {8'h00, 8'h40, 1'b0, 8'h00, 1'b1},  // R6 only los enabled
        {8'h00, 8'hFF, 1'b1, 8'h40, 1'b0}   // R6 R7
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic drive(logic [7:0] v);
        err_cp    = v[7];
        cond_los  = v[6];
        cond_ais  = v[5];
        cond_idle = v[4];
        cond_ferf = v[3];
        cond_aic  = v[2];
        cond_oof  = v[1];
        err_p     = v[0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 0;
        // R1 reset state
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd_addr = 8'h13; #1;
        chk("R1 status", rd_data, 8'h00);
        rd_addr = 8'h10; #1;
        chk("R1 levels", rd_data, 8'h00);
        tick();

        for (int i = 0; i < 16; i++) begin
            drive(VEC[i][25:18]);
            irq_en  = VEC[i][17:10];
            rd_stb  = VEC[i][9];
            rd_addr = 8'h13;
            #1;
            if (VEC[i][9]) chk("R7 R2 read", rd_data, VEC[i][8:1]);
            tick();
            chk("R11 irq", {7'b0, irq}, {7'b0, VEC[i][0]});
        end
        rd_stb = 0;
        drive(8'h00);
        irq_en = 8'hFF;
        tick();

        // R10 level readout and R9 foreign strobe
        cond_ais = 1; cond_idle = 1;
        tick();
        rd_addr = 8'h10; #1;
        chk("R10 levels", rd_data, 8'hA0);
        rd_stb = 1;
        tick();
        chk("R9 strobe at level offset", {7'b0, irq}, 8'h01);
        rd_addr = 8'h12; #1;
        chk("R10 other offset", rd_data, 8'h00);
        tick();
        rd_stb = 0;
        tick(); tick();
        chk("R9 sticky", {7'b0, irq}, 8'h01);
        rd_addr = 8'h13; rd_stb = 1; #1;
        chk("R9 flags kept", rd_data, 8'h30);
        tick();
        rd_stb = 0;
        chk("R7 cleared", {7'b0, irq}, 8'h00);

        // R5 single P pulse, R6 masked CP pulse
        err_p = 1; tick(); err_p = 0; tick();
        irq_en = 8'h7F;
        err_cp = 1; tick(); err_cp = 0; tick();
        irq_en = 8'hFF;
        rd_stb = 1; #1;
        chk("R5 R6 pulses", rd_data, 8'h01);
        tick();
        rd_stb = 0;

        // R1 mid-run reset, released with conditions high
        cond_los = 1;
        tick();
        chk("R3 los before reset", {7'b0, irq}, 8'h01);
        rst = 1;
        tick();
        rst = 0;
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
        rd_addr = 8'h10; #1;
        chk("R1 levels after reset", rd_data, 8'h00);
        tick();
        rd_addr = 8'h13; #1;
        chk("R1 high level after release", rd_data, 8'h70);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule